// File: doc/BRIEF.md
# Timed ADC Channel Sequencer

This block runs an eight-channel successive-approximation converter on a fixed time grid. The input clock is first divided by 1, 2, 3 or 4 to form a tick. A second, selectable count of ticks sets the frame period (2500, 3000, 5000 or 6000 ticks by default). Inside each frame, eight conversion slots begin at fixed tick offsets. A slot starts even if the previous conversion ended early, so the sampling instants carry no jitter. The block drives the multiplexer select, issues a one-cycle start to an external SAR core and accepts that core's done strobe and result.

Slot 5 is time-shared. In even frames (counting from reset) it converts external channel 5. In odd frames it converts the internal offset reference instead. Channel 5 therefore runs at half the frame rate of the other seven channels. Each result is written to the result RAM at the address of the input that was converted. The write goes into the bank that the host is not currently reading. When channel 7 completes, the banks swap and the active-low interrupt output goes low. The host releases the interrupt with a clear pulse, or it releases on its own at the next frame start.

Top module: `adc_frame_sequencer`

## Requirements
- R1: While rst_ni is low: int_no_o is 1, read_bank_o is 0, conv_start_o is 0 and mux_sel_o is 0.
- R2: One tick occurs every (div_sel_i + 1) clock cycles.
- R3: The frame period is FRAME_LEN_n ticks, where n is len_sel_i. The next frame begins on the tick right after the last one, with no idle gap. The first frame begins on the first clock edge after reset is released.
- R4: conv_start_o pulses for one cycle exactly at tick offsets k*SLOT_TICKS for k = 0..7 within each frame, and at no other time. These instants do not depend on when conversions finish.
- R5: At each start, mux_sel_o equals k for slot k. The exception is slot 5 in odd frames, where it equals 8, the offset-reference code. Frame 0 after reset is even.
- R6: A conv_done_i that arrives while a conversion is outstanding produces wr_en_o in the same cycle. wr_addr_o then carries the code of the converted input and wr_data_o carries conv_result_i.
- R7: Every write goes to wr_bank_o = NOT read_bank_o. read_bank_o toggles only on the edge that accepts the result of channel 7.
- R8: int_no_o goes low on the edge that accepts the result of channel 7, and stays low until it is released.
- R9: int_no_o returns high on an edge where clr_i is 1 or the next frame starts. If the channel 7 result and clr_i arrive in the same cycle, int_no_o goes low.
- R10: A conv_done_i that arrives with no conversion outstanding causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Prescaler select; divide ratio is value + 1 |
| len_sel_i | input | 2 | Frame length select (FRAME_LEN_0..3) |
| clr_i | input | 1 | Interrupt acknowledge |
| conv_done_i | input | 1 | Conversion complete from the SAR core |
| conv_result_i | input | RES_W | Conversion result |
| conv_start_o | output | 1 | One-cycle conversion start |
| mux_sel_o | output | 4 | Input select: 0..7 external, 8 offset reference |
| wr_en_o | output | 1 | Result RAM write enable |
| wr_bank_o | output | 1 | Bank being written |
| wr_addr_o | output | 4 | Result address (input code) |
| wr_data_o | output | RES_W | Result data |
| read_bank_o | output | 1 | Bank exposed to the host |
| int_no_o | output | 1 | Frame-complete interrupt, active low |

## Verification
Two events can land in the same cycle: the channel 7 completion that sets the interrupt, and the host clear that releases it. In every third frame, the bench drives clr_i in the exact cycle in which it returns the channel 7 done. It then expects the interrupt to remain low until the next frame start, while the bank still swaps. In the other frames, the clear arrives three cycles later, or it never arrives, so the frame wrap must release the interrupt. The bench sweeps all sixteen divider and length combinations. Each new-frame release is judged against an expected wrap cycle that the bench computes from div_sel_i and the selected length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int unsigned NUM_CH      = 8;
  parameter int unsigned SEL_W       = $clog2(NUM_CH + 1);
  parameter int unsigned SHARED_CH   = 5;
  parameter int unsigned OFFSET_CODE = NUM_CH;
endpackage

// File: rtl/adc_seq_timebase.sv
module adc_seq_timebase
  import adc_seq_pkg::*;
#(
  parameter int unsigned FRAME_LEN_0 = 2500,
  parameter int unsigned FRAME_LEN_1 = 3000,
  parameter int unsigned FRAME_LEN_2 = 5000,
  parameter int unsigned FRAME_LEN_3 = 6000,
  parameter int unsigned SLOT_TICKS  = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic [1:0]       len_sel_i,
  output logic             slot_start_o,
  output logic [SEL_W-1:0] slot_idx_o,
  output logic             frame_wrap_o,
  output logic             first_o
);
  localparam int unsigned MAX_A   = (FRAME_LEN_0 > FRAME_LEN_1) ? FRAME_LEN_0 : FRAME_LEN_1;
  localparam int unsigned MAX_B   = (FRAME_LEN_2 > FRAME_LEN_3) ? FRAME_LEN_2 : FRAME_LEN_3;
  localparam int unsigned MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned FCNT_W  = $clog2(MAX_LEN);
  localparam int unsigned STICK_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;

  logic [1:0]         pre_q;
  logic               tick;
  logic [FCNT_W-1:0]  fcnt_q, len_m1;
  logic [STICK_W-1:0] stick_q;
  logic [SEL_W-1:0]   slot_q;
  logic               new_q, first_q, in_frame;

  always_comb begin
    case (len_sel_i)
      2'd0:    len_m1 = FCNT_W'(FRAME_LEN_0 - 1);
      2'd1:    len_m1 = FCNT_W'(FRAME_LEN_1 - 1);
      2'd2:    len_m1 = FCNT_W'(FRAME_LEN_2 - 1);
      default: len_m1 = FCNT_W'(FRAME_LEN_3 - 1);
    endcase
  end

  assign tick         = (pre_q == 2'd0);
  assign frame_wrap_o = tick & (first_q | (fcnt_q == len_m1));
  assign in_frame     = (slot_q < SEL_W'(NUM_CH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      fcnt_q  <= '0;
      stick_q <= '0;
      slot_q  <= SEL_W'(NUM_CH);
      new_q   <= 1'b0;
      first_q <= 1'b1;
    end else begin
      pre_q <= (pre_q == div_sel_i) ? 2'd0 : pre_q + 2'd1;
      new_q <= tick;
      if (tick) first_q <= 1'b0;
      if (frame_wrap_o) begin
        fcnt_q  <= '0;
        stick_q <= '0;
        slot_q  <= '0;
      end else if (tick) begin
        fcnt_q <= fcnt_q + 1'b1;
        if (in_frame) begin
          if (stick_q == STICK_W'(SLOT_TICKS - 1)) begin
            stick_q <= '0;
            slot_q  <= slot_q + 1'b1;
          end else begin
            stick_q <= stick_q + 1'b1;
          end
        end
      end
    end
  end

  assign slot_start_o = new_q & (stick_q == '0) & in_frame;
  assign slot_idx_o   = slot_q;
  assign first_o      = first_q;
endmodule

// File: rtl/adc_seq_slot_ctrl.sv
module adc_seq_slot_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_start_i,
  input  logic [SEL_W-1:0] slot_idx_i,
  input  logic             frame_wrap_i,
  input  logic             first_i,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic             conv_start_o,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             wr_en_o,
  output logic [SEL_W-1:0] wr_addr_o,
  output logic [RES_W-1:0] wr_data_o,
  output logic             last_done_o
);
  logic             phase_q, busy_q;
  logic [SEL_W-1:0] conv_ch_q;

  always_comb begin
    if (slot_idx_i >= SEL_W'(NUM_CH))
      mux_sel_o = '0;
    else if (slot_idx_i == SEL_W'(SHARED_CH) && phase_q)
      mux_sel_o = SEL_W'(OFFSET_CODE);
    else
      mux_sel_o = slot_idx_i;
  end

  assign conv_start_o = slot_start_i;
  assign wr_en_o      = done_i & busy_q;
  assign wr_addr_o    = conv_ch_q;
  assign wr_data_o    = result_i;
  assign last_done_o  = wr_en_o & (conv_ch_q == SEL_W'(NUM_CH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= 1'b0;
      busy_q    <= 1'b0;
      conv_ch_q <= '0;
    end else begin
      // first wrap after reset opens frame 0 with the phase still cleared
      if (frame_wrap_i) phase_q <= first_i ? 1'b0 : ~phase_q;
      if (slot_start_i) begin
        busy_q    <= 1'b1;
        conv_ch_q <= mux_sel_o;
      end else if (wr_en_o) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_seq_irq_bank.sv
module adc_seq_irq_bank (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic last_done_i,
  input  logic clr_i,
  input  logic frame_wrap_i,
  output logic int_no_o,
  output logic read_bank_o,
  output logic wr_bank_o
);
  logic int_nq, bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_nq <= 1'b1;
      bank_q <= 1'b0;
    end else begin
      // completion has priority over any release in the same cycle
      if (last_done_i) begin
        int_nq <= 1'b0;
        bank_q <= ~bank_q;
      end else if (clr_i || frame_wrap_i) begin
        int_nq <= 1'b1;
      end
    end
  end

  assign int_no_o    = int_nq;
  assign read_bank_o = bank_q;
  assign wr_bank_o   = ~bank_q;
endmodule

// File: rtl/adc_frame_sequencer.sv
module adc_frame_sequencer
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W       = 10,
  parameter int unsigned FRAME_LEN_0 = 2500,
  parameter int unsigned FRAME_LEN_1 = 3000,
  parameter int unsigned FRAME_LEN_2 = 5000,
  parameter int unsigned FRAME_LEN_3 = 6000,
  parameter int unsigned SLOT_TICKS  = 250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic [1:0]       len_sel_i,
  input  logic             clr_i,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  output logic             conv_start_o,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             wr_en_o,
  output logic             wr_bank_o,
  output logic [SEL_W-1:0] wr_addr_o,
  output logic [RES_W-1:0] wr_data_o,
  output logic             read_bank_o,
  output logic             int_no_o
);
  logic             slot_start, frame_wrap, first_frame, last_done;
  logic [SEL_W-1:0] slot_idx;

  adc_seq_timebase #(
    .FRAME_LEN_0(FRAME_LEN_0), .FRAME_LEN_1(FRAME_LEN_1),
    .FRAME_LEN_2(FRAME_LEN_2), .FRAME_LEN_3(FRAME_LEN_3),
    .SLOT_TICKS (SLOT_TICKS)
  ) u_timebase (
    .clk_i, .rst_ni, .div_sel_i, .len_sel_i,
    .slot_start_o(slot_start), .slot_idx_o(slot_idx),
    .frame_wrap_o(frame_wrap), .first_o(first_frame)
  );

  adc_seq_slot_ctrl #(.RES_W(RES_W)) u_slot (
    .clk_i, .rst_ni,
    .slot_start_i(slot_start), .slot_idx_i(slot_idx),
    .frame_wrap_i(frame_wrap), .first_i(first_frame),
    .done_i(conv_done_i), .result_i(conv_result_i),
    .conv_start_o, .mux_sel_o, .wr_en_o, .wr_addr_o, .wr_data_o,
    .last_done_o(last_done)
  );

  adc_seq_irq_bank u_irq (
    .clk_i, .rst_ni, .last_done_i(last_done), .clr_i,
    .frame_wrap_i(frame_wrap), .int_no_o, .read_bank_o, .wr_bank_o
  );
endmodule

// File: rtl/adc_frame_sequencer_chk.sv
module adc_frame_sequencer_chk
  import adc_seq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             conv_done_i,
  input logic             conv_start_o,
  input logic [SEL_W-1:0] mux_sel_o,
  input logic             wr_en_o,
  input logic             wr_bank_o,
  input logic [SEL_W-1:0] wr_addr_o,
  input logic             read_bank_o,
  input logic             int_no_o,
  input logic             frame_wrap
);
  AST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (mux_sel_o <= SEL_W'(OFFSET_CODE))); // R5
  AST_WRITE_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> conv_done_i); // R6
  AST_WRITE_HIDDEN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_bank_o != read_bank_o)); // R7
  AST_SWAP_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(read_bank_o) |-> $past(wr_en_o && (wr_addr_o == SEL_W'(NUM_CH - 1)))); // R7
  AST_INT_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && (wr_addr_o == SEL_W'(NUM_CH - 1))) |=> !int_no_o); // R8
  AST_INT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_no_o) |-> $past(clr_i || frame_wrap)); // R9
endmodule

bind adc_frame_sequencer adc_frame_sequencer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .conv_done_i(conv_done_i),
  .conv_start_o(conv_start_o), .mux_sel_o(mux_sel_o), .wr_en_o(wr_en_o),
  .wr_bank_o(wr_bank_o), .wr_addr_o(wr_addr_o), .read_bank_o(read_bank_o),
  .int_no_o(int_no_o), .frame_wrap(frame_wrap)
);

// File: tb/tb_adc_frame_sequencer.sv
module tb_adc_frame_sequencer;
  localparam int FL0 = 40, FL1 = 48, FL2 = 56, FL3 = 64;
  localparam int SLOT = 4, LAT = 2, NFRAMES = 4, RES_W = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       div_sel_i = '0, len_sel_i = '0;
  logic             clr_i = 1'b0, conv_done_i = 1'b0;
  logic [RES_W-1:0] conv_result_i = '0;
  logic             conv_start_o, wr_en_o, wr_bank_o, read_bank_o, int_no_o;
  logic [3:0]       mux_sel_o, wr_addr_o;
  logic [RES_W-1:0] wr_data_o;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #2 clk_i = ~clk_i;

  adc_frame_sequencer #(
    .RES_W(RES_W), .FRAME_LEN_0(FL0), .FRAME_LEN_1(FL1),
    .FRAME_LEN_2(FL2), .FRAME_LEN_3(FL3), .SLOT_TICKS(SLOT)
  ) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int s);
    case (s)
      0: return FL0;
      1: return FL1;
      2: return FL2;
      default: return FL3;
    endcase
  endfunction

  initial begin
    for (int dsel = 0; dsel < 4; dsel++) begin
      for (int lsel = 0; lsel < 4; lsel++) begin
        int d, p, cd, pend, rel, int_exp, bank_exp;
        d = dsel + 1;
        p = d * len_of(lsel);
        rst_ni = 1'b0; clr_i = 1'b0; conv_done_i = 1'b0;
        div_sel_i = 2'(dsel); len_sel_i = 2'(lsel);
        repeat (3) @(negedge clk_i);
        // R1 reset state
        chk(int_no_o == 1'b1, "R1 int", int_no_o, 1);
        chk(read_bank_o == 1'b0, "R1 bank", read_bank_o, 0);
        chk(conv_start_o == 1'b0, "R1 start", conv_start_o, 0);
        chk(mux_sel_o == 4'd0, "R1 mux", mux_sel_o, 0);
        rst_ni = 1'b1;
        cd = 0; pend = 0; int_exp = 1; bank_exp = 0;
        for (rel = 0; rel < NFRAMES * p; rel++) begin
          int m, fr, k, code, data;
          bit st_exp, real_done, spur, last;
          @(negedge clk_i);
          conv_done_i = 1'b0; clr_i = 1'b0;
          m = rel % p; fr = rel / p;
          st_exp = ((m % (SLOT * d)) == 0) && ((m / (SLOT * d)) < 8);
          k = m / (SLOT * d);
          // R2 R3 R4: start pulses exactly on the computed tick grid
          chk(conv_start_o == st_exp, "R4 start timing", conv_start_o, st_exp);
          chk(int_no_o == int_exp[0], "R8/R9 int level", int_no_o, int_exp);
          chk(read_bank_o == bank_exp[0], "R7 read bank", read_bank_o, bank_exp);
          real_done = 0;
          if (cd > 0) begin
            cd--;
            if (cd == 0) real_done = 1;
          end
          if (st_exp) begin
            code = (k == 5 && (fr % 2) == 1) ? 8 : k;
            chk(mux_sel_o == 4'(code), "R5 mux select", mux_sel_o, code);
            pend = code; cd = LAT;
          end
          last = real_done && (pend == 7);
          spur = !real_done && (fr % 3 == 2) && (m == 8 * SLOT * d + 2);
          data = (rel * 37 + pend) & 10'h3ff;
          conv_result_i = RES_W'(data);
          conv_done_i = real_done | spur;
          if ((fr % 3 == 0) && last) clr_i = 1'b1;                 // R9 collision
          if ((fr % 3 == 1) && (m == 7 * SLOT * d + LAT + 3)) clr_i = 1'b1;
          #1;
          if (real_done) begin
            chk(wr_en_o == 1'b1, "R6 write enable", wr_en_o, 1);
            chk(wr_addr_o == 4'(pend), "R6 write addr", wr_addr_o, pend);
            chk(wr_data_o == RES_W'(data), "R6 write data", wr_data_o, data);
            chk(wr_bank_o == ~bank_exp[0], "R7 write bank", wr_bank_o, 1 - bank_exp);
          end else begin
            chk(wr_en_o == 1'b0, spur ? "R10 stray done" : "R6 no write", wr_en_o, 0);
          end
          if (last) begin
            int_exp = 0; bank_exp = 1 - bank_exp;
          end else if (clr_i || ((rel + 1) % p == 0)) begin
            int_exp = 1;
          end
        end
      end
    end
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule